// File: doc/BRIEF.md
# Event-to-counter mapping table

This block holds the bindings between hardware event identifiers and the programmable performance counters of a core. Software programs a binding by writing a counter's event selector. The block checks the write against a fixed list of supported identifiers and against the set of counters that exist. It then records, rejects or ignores the write.

On the event side, each incoming pulse carries an identifier. The block looks the identifier up in the same cycle and raises a one-hot increment strobe for the counter bound to it, unless that counter is inhibited. A separate query port reports whether a given counter tracks clock cycles or retired instructions. The two fixed counters always do, and a programmable counter does when the matching identifier is bound to it. The counters themselves and their overflow handling sit outside this block.

The table has one entry per supported identifier. Each entry is a valid bit plus a counter index. One counter may therefore own several identifiers at once, while an identifier belongs to at most one counter.

Top module: `pmu_evmap`

## Requirements
- R1: After reset no entry is bound: every event produces `incr` of zero and no programmable counter reports cycles or instructions.
- R2: The identifier is the low 20 bits of `wr_sel` (type in bits 19:16, code in bits 15:0; for cache events code bits 15:3 are the cache id, bits 2:1 the operation and bit 0 the result). The supported identifiers are 0x00001 cycles, 0x00002 retired instructions, 0x10019 data TLB read miss, 0x1001B data TLB write miss and 0x10021 instruction TLB miss. A write of a supported, unbound identifier to an available counter binds it without error.
- R3: A write whose selector is nonzero but whose identifier is not in the supported list raises `wr_err` in the same cycle and leaves the table unchanged.
- R4: A write to counter index 0, 1 or 2, or to an index whose bit in `AVAIL_MASK` is clear, raises `wr_err` in the same cycle and leaves the table unchanged, whatever the selector value.
- R5: A write of selector zero to an available counter removes every binding that targets that counter, raises no error, and leaves bindings of other counters alone.
- R6: A write of an identifier that is already bound raises no error and changes nothing; the identifier stays with its first counter.
- R7: One counter may hold several identifiers at once, and events of each of them strobe that counter.
- R8: `incr` is combinational from `evt_valid` and `evt_id` and is at most one-hot. It has bit k set only when `evt_valid` is high, `evt_id` is bound to counter k and `inhibit[k]` is low; otherwise it is zero.
- R9: `qry_is_cycles` is high for `qry_ctr` 0, and for a counter to which 0x00001 is bound.
- R10: `qry_is_instr` is high for `qry_ctr` 2, and for a counter to which 0x00002 is bound.
- R11: Selector bits above bit 19 do not form part of the identifier. A selector with a supported identifier in its low bits binds it. A selector that is nonzero only above bit 19 carries identifier zero and is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Selector write strobe |
| wr_ctr | input | CIDX_W (5) | Counter index being written |
| wr_sel | input | SEL_W (32) | Selector value written |
| wr_err | output | 1 | Write rejected, same cycle as `wr_en` |
| evt_valid | input | 1 | Event pulse present |
| evt_id | input | 20 | Identifier of the event pulse |
| inhibit | input | NUM_CTRS (32) | Per-counter inhibit mask |
| incr | output | NUM_CTRS (32) | One-hot increment strobe |
| qry_ctr | input | CIDX_W (5) | Counter index being queried |
| qry_is_cycles | output | 1 | Queried counter tracks cycles |
| qry_is_instr | output | 1 | Queried counter tracks retired instructions |

## Verification
The assertions take `wr_en`, `wr_ctr` and `wr_sel` to be stable and known on every clock edge outside reset. They also take `evt_id` and `inhibit` to be known whenever `evt_valid` is high, because `incr` is checked against them combinationally. The stimulus changes all inputs only at falling edges and returns the strobes to zero between operations, so every rising edge sees one clean write or one clean event. Reset is applied only at falling edges and held across a rising edge, so the table is always cleared as a whole.

// File: rtl/pmu_evmap_pkg.sv
// Package: shared widths, slot numbering and the list of supported
// event identifiers for the event-to-counter mapping table.
package pmu_evmap_pkg;

    localparam int EVT_W      = 20;  // identifier width
    localparam int NUM_EVT    = 5;   // supported identifiers, one table slot each
    localparam int SLOT_CYC   = 0;   // slot of the cycle event
    localparam int SLOT_INS   = 1;   // slot of the retired-instruction event
    localparam int FIRST_PROG = 3;   // lowest programmable counter index

    typedef logic [EVT_W-1:0] evt_id_t;

    // Compose a cache event: type 1, code = {cache id, operation, result}
    function automatic evt_id_t cache_evt(input int cache_id, input int op, input int res);
        logic [12:0] cid;
        logic [1:0]  opf;
        logic        rf;
        cid = cache_id[12:0];
        opf = op[1:0];
        rf  = res[0];
        return {4'h1, cid, opf, rf};
    endfunction

    // Identifier held by each table slot
    function automatic evt_id_t slot_code(input int slot);
        case (slot)
            0:       return 20'h00001;            // cycles
            1:       return 20'h00002;            // retired instructions
            2:       return cache_evt(3, 0, 1);   // data TLB read miss
            3:       return cache_evt(3, 1, 1);   // data TLB write miss
            default: return cache_evt(4, 0, 1);   // instruction TLB miss
        endcase
    endfunction

endpackage

// File: rtl/pmu_evmap_decode.sv
// Module: pmu_evmap_decode
// Compares one identifier against every supported identifier and returns a
// hit vector with one bit per table slot.
// Assumes: the supported identifiers are distinct, so at most one bit is set.
module pmu_evmap_decode
    import pmu_evmap_pkg::*;
#(
    parameter int SLOTS = NUM_EVT
) (
    input  evt_id_t          id,
    output logic [SLOTS-1:0] hit
);

    // One comparator per slot
    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
            assign hit[g] = (id == slot_code(g));
        end
    endgenerate

endmodule

// File: rtl/pmu_evmap_table.sv
// Module: pmu_evmap_table
// Holds one entry (valid bit and counter index) per supported identifier and
// applies selector writes: bind, unbind-by-counter, ignore, or reject.
// Assumes: wr_hit is the decode of wr_sel's low identifier bits and has at most
// one bit set; writes are single-cycle strobes.
module pmu_evmap_table
    import pmu_evmap_pkg::*;
#(
    parameter int                NUM_CTRS   = 32,
    parameter int                CIDX_W     = 5,
    parameter int                SEL_W      = 32,
    parameter logic [NUM_CTRS-1:0] AVAIL_MASK = 32'h0000_00F8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [CIDX_W-1:0]                 wr_ctr,
    input  logic [SEL_W-1:0]                  wr_sel,
    input  logic [NUM_EVT-1:0]                wr_hit,
    output logic                              wr_err,
    output logic [NUM_EVT-1:0]                ent_vld,
    output logic [NUM_EVT-1:0][CIDX_W-1:0]    ent_ctr
);

    localparam logic [CIDX_W-1:0] FIRST_IDX = CIDX_W'(FIRST_PROG);

    logic ctr_ok;
    logic sel_zero;
    logic id_listed;
    logic id_taken;
    logic do_clear;
    logic do_bind;

    // Classify the write
    always_comb begin
        ctr_ok    = (wr_ctr >= FIRST_IDX) && AVAIL_MASK[wr_ctr];
        sel_zero  = (wr_sel == '0);
        id_listed = |wr_hit;
        id_taken  = |(wr_hit & ent_vld);
        wr_err    = wr_en && (!ctr_ok || (!sel_zero && !id_listed));
        do_clear  = wr_en && ctr_ok && sel_zero;
        do_bind   = wr_en && ctr_ok && !sel_zero && id_listed && !id_taken;
    end

    // Per-slot storage: clear entries of the written counter, or bind the hit slot
    generate
        for (genvar s = 0; s < NUM_EVT; s++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_vld[s] <= 1'b0;
                    ent_ctr[s] <= '0;
                end else if (do_clear && ent_vld[s] && (ent_ctr[s] == wr_ctr)) begin
                    ent_vld[s] <= 1'b0;
                end else if (do_bind && wr_hit[s]) begin
                    ent_vld[s] <= 1'b1;
                    ent_ctr[s] <= wr_ctr;
                end
            end

            // R2: a live entry always names an available programmable counter
            assert_entry_in_avail_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ent_vld[s] |-> (ent_ctr[s] >= FIRST_IDX) && AVAIL_MASK[ent_ctr[s]]);

            // R6: a live entry survives any write that is not a zero selector
            assert_bound_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (ent_vld[s] && !(wr_en && (wr_sel == '0))) |=> (ent_vld[s] && $stable(ent_ctr[s])));
        end
    endgenerate

    // Last written counter, for the unbind check
    logic [CIDX_W-1:0]  prev_ctr;
    logic [NUM_EVT-1:0] pts_prev;

    // Capture the counter index of each write
    always_ff @(posedge clk) begin
        if (!rst_n) prev_ctr <= '0;
        else        prev_ctr <= wr_ctr;
    end

    // Entries that still point at the previously written counter
    always_comb begin
        for (int s = 0; s < NUM_EVT; s++) pts_prev[s] = ent_vld[s] && (ent_ctr[s] == prev_ctr);
    end

    // R3/R4: a rejected write changes nothing
    assert_err_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> ($stable(ent_vld) && $stable(ent_ctr)));

    // R5: an accepted zero write leaves nothing bound to that counter
    assert_unbind_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err && (wr_sel == '0)) |=> (pts_prev == '0));

    // R4: errors only accompany a write
    assert_err_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> wr_en);

endmodule

// File: rtl/pmu_evmap_route.sv
// Module: pmu_evmap_route
// Turns an event pulse into a one-hot increment strobe for the counter its
// identifier is bound to, masked by the counter inhibit vector.
// Assumes: evt_hit has at most one bit set; the result is combinational.
module pmu_evmap_route
    import pmu_evmap_pkg::*;
#(
    parameter int NUM_CTRS = 32,
    parameter int CIDX_W   = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           evt_valid,
    input  logic [NUM_EVT-1:0]             evt_hit,
    input  logic [NUM_EVT-1:0]             ent_vld,
    input  logic [NUM_EVT-1:0][CIDX_W-1:0] ent_ctr,
    input  logic [NUM_CTRS-1:0]            inhibit,
    output logic [NUM_CTRS-1:0]            incr
);

    // Select the bound counter of the hit slot, unless inhibited
    always_comb begin
        incr = '0;
        for (int s = 0; s < NUM_EVT; s++) begin
            if (evt_valid && evt_hit[s] && ent_vld[s] && !inhibit[ent_ctr[s]])
                incr[ent_ctr[s]] = 1'b1;
        end
    end

    // R8: strobe is at most one-hot
    assert_incr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(incr));

    // R8: no strobe without an event
    assert_incr_needs_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |-> (incr == '0));

    // R8: an inhibited counter is never strobed
    assert_incr_not_inhibited_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (incr & inhibit) == '0);

endmodule

// File: rtl/pmu_evmap.sv
// Module: pmu_evmap (top)
// Event-to-counter mapping table: accepts selector writes, routes event
// pulses to counter increment strobes and answers the cycle/instruction query.
// Assumes: counter 0 is the fixed cycle counter, counter 2 the fixed
// retired-instruction counter; NUM_CTRS matches the width of AVAIL_MASK.
module pmu_evmap
    import pmu_evmap_pkg::*;
#(
    parameter int                  NUM_CTRS   = 32,
    parameter int                  SEL_W      = 32,
    parameter logic [NUM_CTRS-1:0] AVAIL_MASK = 32'h0000_00F8,
    localparam int                 CIDX_W     = $clog2(NUM_CTRS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CIDX_W-1:0]   wr_ctr,
    input  logic [SEL_W-1:0]    wr_sel,
    output logic                wr_err,
    input  logic                evt_valid,
    input  logic [EVT_W-1:0]    evt_id,
    input  logic [NUM_CTRS-1:0] inhibit,
    output logic [NUM_CTRS-1:0] incr,
    input  logic [CIDX_W-1:0]   qry_ctr,
    output logic                qry_is_cycles,
    output logic                qry_is_instr
);

    localparam logic [CIDX_W-1:0] CYC_FIXED = '0;
    localparam logic [CIDX_W-1:0] INS_FIXED = CIDX_W'(2);

    logic [NUM_EVT-1:0]             wr_hit;
    logic [NUM_EVT-1:0]             evt_hit;
    logic [NUM_EVT-1:0]             ent_vld;
    logic [NUM_EVT-1:0][CIDX_W-1:0] ent_ctr;

    pmu_evmap_decode #(.SLOTS(NUM_EVT)) u_dec_wr (
        .id  (wr_sel[EVT_W-1:0]),
        .hit (wr_hit)
    );

    pmu_evmap_decode #(.SLOTS(NUM_EVT)) u_dec_evt (
        .id  (evt_id),
        .hit (evt_hit)
    );

    pmu_evmap_table #(
        .NUM_CTRS   (NUM_CTRS),
        .CIDX_W     (CIDX_W),
        .SEL_W      (SEL_W),
        .AVAIL_MASK (AVAIL_MASK)
    ) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ctr  (wr_ctr),
        .wr_sel  (wr_sel),
        .wr_hit  (wr_hit),
        .wr_err  (wr_err),
        .ent_vld (ent_vld),
        .ent_ctr (ent_ctr)
    );

    pmu_evmap_route #(
        .NUM_CTRS (NUM_CTRS),
        .CIDX_W   (CIDX_W)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_hit   (evt_hit),
        .ent_vld   (ent_vld),
        .ent_ctr   (ent_ctr),
        .inhibit   (inhibit),
        .incr      (incr)
    );

    // Query: fixed counters, or the counter bound to the cycle/instruction slot
    always_comb begin
        qry_is_cycles = (qry_ctr == CYC_FIXED) ||
                        (ent_vld[SLOT_CYC] && (ent_ctr[SLOT_CYC] == qry_ctr));
        qry_is_instr  = (qry_ctr == INS_FIXED) ||
                        (ent_vld[SLOT_INS] && (ent_ctr[SLOT_INS] == qry_ctr));
    end

endmodule

// File: tb/sim_pmu_evmap.sv
`timescale 1ns/1ps
module sim_pmu_evmap;

    localparam int NC = 32;

    typedef struct {
        int          kind;   // 0 incr, 1 wr_err, 2 {qry_is_cycles, qry_is_instr}
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_ctr = '0;
    logic [31:0] wr_sel = '0;
    logic        wr_err;
    logic        evt_valid = 1'b0;
    logic [19:0] evt_id = '0;
    logic [NC-1:0] inhibit = '0;
    logic [NC-1:0] incr;
    logic [4:0]  qry_ctr = '0;
    logic        qry_is_cycles;
    logic        qry_is_instr;

    item_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    pmu_evmap u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_ctr(wr_ctr), .wr_sel(wr_sel), .wr_err(wr_err),
        .evt_valid(evt_valid), .evt_id(evt_id), .inhibit(inhibit), .incr(incr),
        .qry_ctr(qry_ctr), .qry_is_cycles(qry_is_cycles), .qry_is_instr(qry_is_instr)
    );

    task automatic quiet();
        wr_en = 1'b0; evt_valid = 1'b0; inhibit = '0;
    endtask

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic do_wr(input int ctr, input logic [31:0] sel, input bit exp_err, input string tag);
        @(negedge clk);
        quiet();
        wr_en = 1'b1; wr_ctr = ctr[4:0]; wr_sel = sel;
        push(1, {31'd0, exp_err}, tag);
    endtask

    task automatic do_ev(input bit vld, input logic [19:0] id, input logic [NC-1:0] inh,
                         input logic [NC-1:0] exp, input string tag);
        @(negedge clk);
        quiet();
        evt_valid = vld; evt_id = id; inhibit = inh;
        push(0, exp, tag);
    endtask

    task automatic do_qry(input int ctr, input bit ec, input bit ei, input string tag);
        @(negedge clk);
        quiet();
        qry_ctr = ctr[4:0];
        push(2, {30'd0, ec, ei}, tag);
    endtask

    // Monitor: compare queued expectations after the inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = incr;
                    1:       act = {31'd0, wr_err};
                    default: act = {30'd0, qry_is_cycles, qry_is_instr};
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty table after reset
        do_ev(1, 20'h00001, '0, '0, "R1 no binding after reset");
        do_qry(3, 0, 0, "R1 programmable counter idle");
        do_qry(0, 1, 0, "R9 fixed cycle counter");
        do_qry(2, 0, 1, "R10 fixed instruction counter");

        // R2: bind and route
        do_wr(3, 32'h00001, 0, "R2 bind cycles to 3");
        do_ev(1, 20'h00001, '0, 32'h1 << 3, "R2 cycles routes to 3");
        do_qry(3, 1, 0, "R9 bound cycle counter");
        do_wr(4, 32'h00002, 0, "R2 bind instr to 4");
        do_ev(1, 20'h00002, '0, 32'h1 << 4, "R2 instr routes to 4");
        do_qry(4, 0, 1, "R10 bound instr counter");

        // R6: already bound identifier is ignored
        do_wr(5, 32'h00001, 0, "R6 rebind no error");
        do_ev(1, 20'h00001, '0, 32'h1 << 3, "R6 binding kept on 3");
        do_qry(5, 0, 0, "R6 counter 5 not cycles");

        // R3: unsupported identifier
        do_wr(5, 32'h00123, 1, "R3 unsupported rejected");
        do_ev(1, 20'h00123, '0, '0, "R3 no route for unsupported");

        // R4: bad counter index
        do_wr(2, 32'h10019, 1, "R4 fixed index rejected");
        do_wr(8, 32'h10019, 1, "R4 unavailable index rejected");
        do_ev(1, 20'h10019, '0, '0, "R4 nothing bound");
        do_wr(1, 32'h0, 1, "R4 zero to fixed index rejected");

        // R7: several identifiers on one counter
        do_wr(5, 32'h10019, 0, "R7 bind dtlb read to 5");
        do_wr(5, 32'h1001B, 0, "R7 bind dtlb write to 5");
        do_ev(1, 20'h10019, '0, 32'h1 << 5, "R7 dtlb read routes to 5");
        do_ev(1, 20'h1001B, '0, 32'h1 << 5, "R7 dtlb write routes to 5");

        // R11: high selector bits
        do_wr(6, 32'hFFF1_0021, 0, "R11 high bits ignored in id");
        do_ev(1, 20'h10021, '0, 32'h1 << 6, "R11 itlb routes to 6");
        do_wr(7, 32'h0010_0000, 1, "R11 zero id nonzero sel rejected");

        // R8: inhibit and valid gating
        do_ev(1, 20'h10021, 32'h1 << 6, '0, "R8 inhibited counter silent");
        do_ev(1, 20'h10021, 32'h1 << 5, 32'h1 << 6, "R8 other inhibit no effect");
        do_ev(0, 20'h00001, '0, '0, "R8 no event no strobe");
        do_ev(1, 20'h00003, '0, '0, "R8 unbound id silent");

        // R5: unbind all of counter 5
        do_wr(5, 32'h0, 0, "R5 zero write accepted");
        do_ev(1, 20'h10019, '0, '0, "R5 dtlb read unbound");
        do_ev(1, 20'h1001B, '0, '0, "R5 dtlb write unbound");
        do_ev(1, 20'h00001, '0, 32'h1 << 3, "R5 other counter kept");
        do_wr(6, 32'h10019, 0, "R5 rebind after unbind");
        do_ev(1, 20'h10019, '0, 32'h1 << 6, "R5 rebound routes to 6");
        do_ev(1, 20'h10021, '0, 32'h1 << 6, "R7 6 still holds itlb");
        do_wr(3, 32'h0, 0, "R5 unbind cycles");
        do_qry(3, 0, 0, "R9 unbound counter not cycles");
        do_wr(7, 32'h00001, 0, "R2 bind cycles to 7");
        do_qry(7, 1, 0, "R9 cycles moved to 7");

        // R1: reset mid-run clears all
        @(negedge clk);
        quiet();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_ev(1, 20'h00002, '0, '0, "R1 reset clears instr");
        do_qry(7, 0, 0, "R1 reset clears cycles");

        @(negedge clk);
        quiet();
        #2;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule